// File: doc/BRIEF.md
# Conditional Relative Branch Sequencer

This block resolves the short conditional branches of a 16-bit coprocessor. The instruction issue stage presents one instruction per `issue` strobe. With it come the opcode byte, the byte after the opcode and the address of the opcode. The stage also presents the current sign, zero, carry and overflow flags. One clock later the block returns the address to fetch next (`next_pc`, qualified by `npc_valid`). It also reports whether a branch condition held (`taken`) and, one instruction later, whether fetch must jump (`redirect`).

Branch opcodes 0x05 to 0x0F are two bytes long: the opcode and a signed 8-bit displacement. A one-stage prefetch pipe always fetches the byte after the displacement, so that instruction, the delay slot, executes whether or not the branch is taken. The block therefore resolves a branch in two steps, managed by a two-state sequencer:

- `S_IDLE`: normal sequential flow. Transition `T_BRANCH` goes to `S_SLOT` when an issued opcode is a branch. A non-branch issue, or no issue, stays in `S_IDLE`.
- `S_SLOT`: a branch decision is pending while the delay slot is awaited. Transition `T_RESOLVE` returns to `S_IDLE` on the next issue, which is the slot instruction. It applies the pending decision to that issue's `next_pc`. Cycles without an issue stay in `S_SLOT` and keep the decision.

Top module: `rel_branch_unit`

## Requirements
- R1: While `rst_n` is low and after its release, before any issue, `npc_valid`, `taken` and `redirect` are 0, `next_pc` is 0 and the sequencer is in `S_IDLE`.
- R2: In `S_IDLE`, an issued opcode outside 0x05..0x0F gives, on the next cycle, `npc_valid`=1, `next_pc` = pc+1, `taken`=0 and `redirect`=0.
- R3: Opcode 0x05 is taken regardless of the flags.
- R4: Opcode 0x06 is taken when sign XOR overflow is 0, and opcode 0x07 is taken when sign XOR overflow is 1.
- R5: Opcode 0x08 is taken when zero is 0, and opcode 0x09 is taken when zero is 1.
- R6: Opcode 0x0A is taken when sign is 0, and opcode 0x0B is taken when sign is 1.
- R7: Opcodes 0x0C and 0x0D are taken on carry 0 and carry 1. Opcodes 0x0E and 0x0F are taken on overflow 0 and overflow 1.
- R8: A branch issued in `S_IDLE` gives, on the next cycle, `npc_valid`=1, `taken` = its condition, `redirect`=0 and `next_pc` = pc+2, the delay-slot address, whether or not it is taken.
- R9: The first issue after a branch (the delay slot) gives `redirect` = the branch's `taken`. Its `next_pc` is the branch pc+2 plus the sign-extended displacement when taken, and the slot's pc+1 otherwise.
- R10: A branch opcode issued in the delay slot is not evaluated. It yields `taken`=0, the pending decision alone sets `next_pc`, and the sequencer returns to `S_IDLE`.
- R11: A cycle without an issue gives `npc_valid`=0, `taken`=0 and `redirect`=0 on the next cycle, leaves `next_pc` unchanged, and keeps any pending branch decision.
- R12: The target is computed modulo 2^16, both forward past 0xFFFF and backward below 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Opcode byte of the issued instruction |
| disp | input | 8 | Byte following the opcode (signed displacement for branches) |
| pc | input | 16 | Address of the opcode byte |
| flag_sign | input | 1 | Sign flag |
| flag_zero | input | 1 | Zero flag |
| flag_carry | input | 1 | Carry flag |
| flag_ovf | input | 1 | Overflow flag |
| npc_valid | output | 1 | `next_pc` belongs to the previous cycle's issue |
| next_pc | output | 16 | Address to fetch next |
| taken | output | 1 | The branch issued last cycle met its condition |
| redirect | output | 1 | The slot issued last cycle ends a taken branch; fetch jumps |

## Verification
The assertions check on every cycle that a branch in `S_IDLE` always yields the slot address, and that non-branch issues step by one. They also check that `redirect` follows only a slot issue, that `taken` follows only a branch evaluated in `S_IDLE`, that 0x05 is always taken, and that empty cycles hold `next_pc`. Only the bench scenarios show the actual condition table for each flag pattern and the target arithmetic, including wraparound. They also show that a pending decision survives idle cycles, and how a branch sitting in the delay slot is handled.

// File: rtl/rbu_pkg.sv
package rbu_pkg;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_SLOT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic carry;
        logic ovf;
    } flags_t;

    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OP_BR_ALWAYS = 8'h05;
    localparam logic [OP_W-1:0] OP_BR_GE     = 8'h06;
    localparam logic [OP_W-1:0] OP_BR_LT     = 8'h07;
    localparam logic [OP_W-1:0] OP_BR_NZ     = 8'h08;
    localparam logic [OP_W-1:0] OP_BR_Z      = 8'h09;
    localparam logic [OP_W-1:0] OP_BR_POS    = 8'h0A;
    localparam logic [OP_W-1:0] OP_BR_NEG    = 8'h0B;
    localparam logic [OP_W-1:0] OP_BR_NC     = 8'h0C;
    localparam logic [OP_W-1:0] OP_BR_C      = 8'h0D;
    localparam logic [OP_W-1:0] OP_BR_NV     = 8'h0E;
    localparam logic [OP_W-1:0] OP_BR_V      = 8'h0F;

endpackage

// File: rtl/rbu_cond.sv
module rbu_cond
    import rbu_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  flags_t          flags,
    output logic            is_branch,
    output logic            cond_ok
);

    logic signed_lt;

    assign signed_lt = flags.sign ^ flags.ovf;

    always_comb begin
        is_branch = 1'b1;
        cond_ok   = 1'b0;
        case (opcode)
            OP_BR_ALWAYS: cond_ok = 1'b1;
            OP_BR_GE:     cond_ok = ~signed_lt;
            OP_BR_LT:     cond_ok = signed_lt;
            OP_BR_NZ:     cond_ok = ~flags.zero;
            OP_BR_Z:      cond_ok = flags.zero;
            OP_BR_POS:    cond_ok = ~flags.sign;
            OP_BR_NEG:    cond_ok = flags.sign;
            OP_BR_NC:     cond_ok = ~flags.carry;
            OP_BR_C:      cond_ok = flags.carry;
            OP_BR_NV:     cond_ok = ~flags.ovf;
            OP_BR_V:      cond_ok = flags.ovf;
            default: begin
                is_branch = 1'b0;
                cond_ok   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rbu_target.sv
module rbu_target #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    output logic [PC_W-1:0]   seq_pc,
    output logic [PC_W-1:0]   slot_pc,
    output logic [PC_W-1:0]   target
);

    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] disp_ext;

    generate
        if (EXT_W > 0) begin : g_extend
            assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[PC_W-1:0];
        end
    endgenerate

    assign seq_pc  = pc + PC_W'(1);
    assign slot_pc = pc + PC_W'(2);
    assign target  = slot_pc + disp_ext;

endmodule

// File: rtl/rbu_seq.sv
module rbu_seq
    import rbu_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic            is_branch,
    input  logic            cond_ok,
    input  logic [PC_W-1:0] seq_pc,
    input  logic [PC_W-1:0] slot_pc,
    input  logic [PC_W-1:0] target,
    output logic            in_slot,
    output logic            npc_valid,
    output logic [PC_W-1:0] next_pc,
    output logic            taken,
    output logic            redirect
);

    seq_state_e      state_q, state_d;
    logic            pend_taken_q;
    logic [PC_W-1:0] pend_target_q;

    // Next-state logic: T_BRANCH and T_RESOLVE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (issue && is_branch) state_d = S_SLOT;
            S_SLOT: if (issue)              state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign in_slot = (state_q == S_SLOT);

    // Output and pending-decision registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            npc_valid     <= 1'b0;
            next_pc       <= '0;
            taken         <= 1'b0;
            redirect      <= 1'b0;
            pend_taken_q  <= 1'b0;
            pend_target_q <= '0;
        end else begin
            npc_valid <= issue;
            taken     <= 1'b0;
            redirect  <= 1'b0;
            if (issue) begin
                unique case (state_q)
                    S_IDLE: begin
                        if (is_branch) begin
                            next_pc       <= slot_pc;
                            taken         <= cond_ok;
                            pend_taken_q  <= cond_ok;
                            pend_target_q <= target;
                        end else begin
                            next_pc <= seq_pc;
                        end
                    end
                    S_SLOT: begin
                        redirect <= pend_taken_q;
                        next_pc  <= pend_taken_q ? pend_target_q : seq_pc;
                    end
                endcase
            end
        end
    end

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !is_branch && state_q == S_IDLE) |=> (npc_valid && !taken && next_pc == $past(seq_pc))); // R2

    AST_SLOT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_branch && state_q == S_IDLE) |=> (npc_valid && !redirect && next_pc == $past(slot_pc))); // R8

    AST_REDIRECT_FROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> ($past(issue) && $past(state_q) == S_SLOT)); // R9

    AST_TAKEN_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> ($past(issue) && $past(is_branch) && $past(state_q) == S_IDLE)); // R10

    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!npc_valid && !taken && !redirect && $stable(next_pc))); // R11

endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
    import rbu_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DISP_W-1:0] disp,
    input  logic [PC_W-1:0]   pc,
    input  logic              flag_sign,
    input  logic              flag_zero,
    input  logic              flag_carry,
    input  logic              flag_ovf,
    output logic              npc_valid,
    output logic [PC_W-1:0]   next_pc,
    output logic              taken,
    output logic              redirect
);

    flags_t          flags;
    logic            is_branch, cond_ok, in_slot;
    logic [PC_W-1:0] seq_pc, slot_pc, target;

    assign flags = '{sign: flag_sign, zero: flag_zero, carry: flag_carry, ovf: flag_ovf};

    rbu_cond u_cond (
        .opcode    (opcode),
        .flags     (flags),
        .is_branch (is_branch),
        .cond_ok   (cond_ok)
    );

    rbu_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_target (
        .pc      (pc),
        .disp    (disp),
        .seq_pc  (seq_pc),
        .slot_pc (slot_pc),
        .target  (target)
    );

    rbu_seq #(.PC_W(PC_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .is_branch (is_branch),
        .cond_ok   (cond_ok),
        .seq_pc    (seq_pc),
        .slot_pc   (slot_pc),
        .target    (target),
        .in_slot   (in_slot),
        .npc_valid (npc_valid),
        .next_pc   (next_pc),
        .taken     (taken),
        .redirect  (redirect)
    );

    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !in_slot && opcode == OP_BR_ALWAYS) |=> taken); // R3

    AST_NONBRANCH_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (opcode < OP_BR_ALWAYS || opcode > OP_BR_V)) |=> !taken); // R2

endmodule

// File: tb/test_rel_branch_unit.sv
`timescale 1ns/1ps
module test_rel_branch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  disp = '0;
    logic [15:0] pc = '0;
    logic        fs = 1'b0, fz = 1'b0, fc = 1'b0, fv = 1'b0;
    logic        npc_valid, taken, redirect;
    logic [15:0] next_pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rel_branch_unit i_rel_branch_unit (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .disp(disp), .pc(pc),
        .flag_sign(fs), .flag_zero(fz), .flag_carry(fc), .flag_ovf(fv),
        .npc_valid(npc_valid), .next_pc(next_pc), .taken(taken), .redirect(redirect)
    );

    // {opcode, disp, pc, flags{s,z,c,v}, expected taken}
    localparam logic [36:0] VEC [16] = '{
        {8'h05, 8'h10, 16'h0100, 4'b0000, 1'b1},
        {8'h06, 8'h04, 16'h0200, 4'b1001, 1'b1},
        {8'h06, 8'h04, 16'h0200, 4'b1000, 1'b0},
        {8'h07, 8'hFC, 16'h0300, 4'b0001, 1'b1},
        {8'h07, 8'hFC, 16'h0300, 4'b0000, 1'b0},
        {8'h08, 8'h08, 16'h0400, 4'b0000, 1'b1},
        {8'h08, 8'h08, 16'h0400, 4'b0100, 1'b0},
        {8'h09, 8'h08, 16'h0400, 4'b0100, 1'b1},
        {8'h0A, 8'h02, 16'h0500, 4'b1000, 1'b0},
        {8'h0B, 8'h02, 16'h0500, 4'b1000, 1'b1},
        {8'h0C, 8'h06, 16'h0600, 4'b0010, 1'b0},
        {8'h0D, 8'h06, 16'h0600, 4'b0010, 1'b1},
        {8'h0E, 8'h7F, 16'h0700, 4'b0001, 1'b0},
        {8'h0F, 8'h7F, 16'h0700, 4'b0001, 1'b1},
        {8'h0F, 8'h20, 16'hFFF0, 4'b0001, 1'b1},
        {8'h05, 8'h80, 16'h0003, 4'b0000, 1'b1}
    };

    function automatic string req_of(input logic [7:0] op);
        case (op)
            8'h06, 8'h07: return "R4";
            8'h08, 8'h09: return "R5";
            8'h0A, 8'h0B: return "R6";
            8'h0C, 8'h0D, 8'h0E, 8'h0F: return "R7";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] op, input logic [7:0] d,
                        input logic [15:0] p, input logic [3:0] f);
        @(negedge clk);
        issue = 1'b1; opcode = op; disp = d; pc = p;
        {fs, fz, fc, fv} = f;
        @(posedge clk);
        #1;
        issue = 1'b0;
    endtask

    task automatic empty_cycle();
        @(negedge clk);
        issue = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", {npc_valid, taken, redirect}, 3'b000);
        chk("R1", next_pc, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", {npc_valid, taken, redirect}, 3'b000);
        chk("R1", next_pc, 16'h0000);

        // Non-branch opcodes at the range edges
        step(8'h04, 8'h33, 16'h1234, 4'b1111);
        chk("R2", npc_valid, 1'b1);
        chk("R2", next_pc, 16'h1235);
        chk("R2", {taken, redirect}, 2'b00);
        step(8'h10, 8'h33, 16'h2000, 4'b0000);
        chk("R2", next_pc, 16'h2001);
        chk("R2", {taken, redirect}, 2'b00);

        // Table of branches, each followed by its delay slot
        for (int i = 0; i < 16; i++) begin
            logic [7:0]  op, d;
            logic [15:0] p, slot, tgt;
            logic [3:0]  f;
            logic        e;
            op = VEC[i][36:29]; d = VEC[i][28:21]; p = VEC[i][20:5];
            f = VEC[i][4:1];    e = VEC[i][0];
            slot = p + 16'd2;
            tgt  = slot + {{8{d[7]}}, d};
            step(op, d, p, f);
            chk(req_of(op), taken, e);
            chk("R8", {npc_valid, redirect}, 2'b10);
            chk("R8", next_pc, slot);
            step(8'h01, 8'h00, slot, ~f);
            chk("R9", redirect, e);
            chk((i >= 14) ? "R12" : "R9", next_pc, e ? tgt : slot + 16'd1);
        end

        // Pending decision survives empty cycles
        step(8'h0D, 8'h40, 16'h3000, 4'b0010);
        chk("R8", next_pc, 16'h3002);
        empty_cycle();
        chk("R11", {npc_valid, taken, redirect}, 3'b000);
        chk("R11", next_pc, 16'h3002);
        empty_cycle();
        chk("R11", next_pc, 16'h3002);
        step(8'h01, 8'h00, 16'h3002, 4'b0000);
        chk("R11", redirect, 1'b1);
        chk("R11", next_pc, 16'h3042);

        // Branch in the delay slot is not evaluated
        step(8'h05, 8'h10, 16'h0800, 4'b0000);
        step(8'h09, 8'h20, 16'h0802, 4'b0100);
        chk("R10", taken, 1'b0);
        chk("R10", redirect, 1'b1);
        chk("R10", next_pc, 16'h0812);
        step(8'h01, 8'h00, 16'h0812, 4'b0000);
        chk("R10", next_pc, 16'h0813);
        chk("R10", {taken, redirect}, 2'b00);

        // Not-taken branch in slot after a not-taken branch
        step(8'h08, 8'h10, 16'h0900, 4'b0100);
        chk("R5", taken, 1'b0);
        step(8'h05, 8'h10, 16'h0902, 4'b0000);
        chk("R10", {taken, redirect}, 2'b00);
        chk("R10", next_pc, 16'h0903);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule